// File: doc/BRIEF.md
# Multichannel CIC Decimator

This block is a cascaded integrator-comb decimator for several channels that share one input stream. Samples come in one per valid cycle, each tagged with its channel index. The channels arrive in a fixed round: 0, 1, up to the last channel, and then the round starts again. Each arriving sample passes through a chain of integrators that belongs to its own channel. The integrators wrap on overflow. At the end of every R rounds, the comb chain of that channel turns the integrator output into one decimated sample. This decimated sample leaves the block one cycle later, tagged with the same channel index.

The number of stages and the comb lag (1 or 2 decimated samples) are fixed when the block is built. The ratio R comes either from a build parameter or from a runtime input. The runtime input is held to a configured range, and it is sampled only when a new output period begins. The output keeps full internal precision, and a later block reduces the word length.

Top module: `cic_decimator`

## Requirements
- R1: Reset is synchronous and active high. While reset is held, `outValid` stays low, even if samples are presented. All integrator and comb state is cleared, so the first outputs after reset equal those of a filter that starts from zero.
- R2: The channels are independent. A sample tagged with channel c only changes the output of channel c.
- R3: A round ends on a valid sample whose channel index is NUM_CH-1. In the R-th round of each output period, every valid sample for channel c produces exactly one output on the next cycle: `outValid` is high and `outCh` equals c. No other sample produces an output.
- R4: Each output equals the N-th order difference, at lag DIFF_DELAY, of the sequence of decimated values of the channel's N-fold running sum of its sign-extended inputs. The result is taken modulo 2^ACC_W.
- R5: ACC_W is IN_W + N·clog2(RATE_MAX·DIFF_DELAY). A constant input of the most negative value, at the largest ratio, settles to -2^(ACC_W-1) without error.
- R6: With VAR_RATE set, the ratio is sampled from `rateIn` only on the valid channel-0 sample that begins an output period. A change of `rateIn` in the middle of a period has no effect on that period.
- R7: A `rateIn` value below RATE_MIN acts as RATE_MIN. A value above RATE_MAX acts as RATE_MAX.
- R8: Cycles with `inValid` low change no state and produce no output, whatever `inCh` and `inData` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Input sample qualifier |
| inCh | input | CH_W | Channel index of the input sample |
| inData | input | IN_W | Signed input sample |
| rateIn | input | RATE_W | Requested decimation ratio (variable mode) |
| outValid | output | 1 | Output sample qualifier |
| outCh | output | CH_W | Channel index of the output sample |
| outData | output | ACC_W | Signed full-precision decimated sample |

## Verification
The test inputs are:
- A per-channel impulse, which exposes the shape of the impulse response and the alignment of the output periods.
- An impulse on a single channel, which shows whether state leaks between channels.
- A steady most-negative input at the largest ratio, which checks the full DC gain at the edge of the word width.
- Random and alternating full-scale sequences, which exercise the wrap-around arithmetic with both signs.

Directed runs cover four further cases:
- Idle cycles carrying junk data.
- A ratio change in the middle of a period.
- Requested ratios outside the configured range, which show whether the ratio is clamped and latched correctly.
- Samples presented while reset is held.

// File: rtl/cic_dec_pkg.sv
package cic_dec_pkg;
  // Strobes handed from the sequencing logic to the arithmetic
  typedef struct packed {
    logic integEn;  // accumulate the current sample into its channel
    logic combEn;   // this sample closes an output period for its channel
  } cicStrobe_t;
endpackage

// File: rtl/cic_dec_ctrl.sv
module cic_dec_ctrl
  import cic_dec_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int CH_W       = 2,
  parameter int RATE_W     = 4,
  parameter int RATE_MIN   = 2,
  parameter int RATE_MAX   = 8,
  parameter bit VAR_RATE   = 1'b1,
  parameter int FIXED_RATE = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [CH_W-1:0]   inCh,
  input  logic [RATE_W-1:0] rateIn,
  output cicStrobe_t        strobe
);
  logic [RATE_W-1:0] reqRate;
  logic [RATE_W-1:0] activeRate;
  logic [RATE_W-1:0] frameCnt;
  logic              periodStart;
  logic              frameEnd;
  logic              lastFrame;

  generate
    if (VAR_RATE) begin : g_varRate
      always_comb begin
        if (rateIn < RATE_W'(RATE_MIN))      reqRate = RATE_W'(RATE_MIN);
        else if (rateIn > RATE_W'(RATE_MAX)) reqRate = RATE_W'(RATE_MAX);
        else                                 reqRate = rateIn;
      end
    end else begin : g_fixRate
      assign reqRate = RATE_W'(FIXED_RATE);
    end
  endgenerate

  assign periodStart = inValid && (inCh == '0) && (frameCnt == '0);
  assign frameEnd    = inValid && (inCh == CH_W'(NUM_CH - 1));
  assign lastFrame   = (frameCnt == activeRate - RATE_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      activeRate <= RATE_W'(RATE_MIN);
      frameCnt   <= '0;
    end else begin
      if (periodStart) activeRate <= reqRate;
      if (frameEnd)    frameCnt   <= lastFrame ? '0 : frameCnt + RATE_W'(1);
    end
  end

  always_comb begin
    strobe.integEn = inValid;
    strobe.combEn  = inValid && lastFrame;
  end
endmodule

// File: rtl/cic_dec_datapath.sv
module cic_dec_datapath
  import cic_dec_pkg::*;
#(
  parameter int IN_W       = 8,
  parameter int NUM_CH     = 4,
  parameter int CH_W       = 2,
  parameter int STAGES     = 3,
  parameter int DIFF_DELAY = 2,
  parameter int ACC_W      = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  cicStrobe_t       strobe,
  input  logic [CH_W-1:0]  inCh,
  input  logic [IN_W-1:0]  inData,
  output logic             outValid,
  output logic [CH_W-1:0]  outCh,
  output logic [ACC_W-1:0] outData
);
  logic [ACC_W-1:0] xExt;
  logic [ACC_W-1:0] combHead;

  assign xExt = {{(ACC_W-IN_W){inData[IN_W-1]}}, inData};

  // Integrator cascade, state interleaved per channel, wrap-around sums
  for (genvar k = 0; k < STAGES; k++) begin : g_int
    logic [ACC_W-1:0] state [NUM_CH];
    logic [ACC_W-1:0] sum;
    if (k == 0) begin : g_first
      assign sum = xExt + state[inCh];
    end else begin : g_next
      assign sum = g_int[k-1].sum + state[inCh];
    end
    always_ff @(posedge clk) begin
      if (rst) begin
        for (int c = 0; c < NUM_CH; c++) state[c] <= '0;
      end else if (strobe.integEn) begin
        state[inCh] <= sum;
      end
    end
  end

  assign combHead = g_int[STAGES-1].sum;

  // Comb cascade at the output rate, per-channel delay lines
  for (genvar k = 0; k < STAGES; k++) begin : g_comb
    logic [ACC_W-1:0] dly [NUM_CH][DIFF_DELAY];
    logic [ACC_W-1:0] din;
    logic [ACC_W-1:0] dout;
    if (k == 0) begin : g_first
      assign din = combHead;
    end else begin : g_next
      assign din = g_comb[k-1].dout;
    end
    assign dout = din - dly[inCh][DIFF_DELAY-1];
    always_ff @(posedge clk) begin
      if (rst) begin
        for (int c = 0; c < NUM_CH; c++)
          for (int j = 0; j < DIFF_DELAY; j++) dly[c][j] <= '0;
      end else if (strobe.combEn) begin
        dly[inCh][0] <= din;
        for (int j = 1; j < DIFF_DELAY; j++) dly[inCh][j] <= dly[inCh][j-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      outCh    <= '0;
      outData  <= '0;
    end else begin
      outValid <= strobe.combEn;
      if (strobe.combEn) begin
        outCh   <= inCh;
        outData <= g_comb[STAGES-1].dout;
      end
    end
  end
endmodule

// File: rtl/cic_decimator.sv
module cic_decimator
  import cic_dec_pkg::*;
#(
  parameter int IN_W       = 8,
  parameter int NUM_CH     = 4,
  parameter int STAGES     = 3,
  parameter int DIFF_DELAY = 2,
  parameter int RATE_MIN   = 2,
  parameter int RATE_MAX   = 8,
  parameter bit VAR_RATE   = 1'b1,
  parameter int FIXED_RATE = 4,
  localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int RATE_W    = $clog2(RATE_MAX + 1),
  localparam int ACC_W     = IN_W + STAGES * $clog2(RATE_MAX * DIFF_DELAY)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [CH_W-1:0]   inCh,
  input  logic [IN_W-1:0]   inData,
  input  logic [RATE_W-1:0] rateIn,
  output logic              outValid,
  output logic [CH_W-1:0]   outCh,
  output logic [ACC_W-1:0]  outData
);
  cicStrobe_t strobe;

  cic_dec_ctrl #(
    .NUM_CH(NUM_CH), .CH_W(CH_W), .RATE_W(RATE_W), .RATE_MIN(RATE_MIN),
    .RATE_MAX(RATE_MAX), .VAR_RATE(VAR_RATE), .FIXED_RATE(FIXED_RATE)
  ) u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .inCh(inCh),
    .rateIn(rateIn), .strobe(strobe)
  );

  cic_dec_datapath #(
    .IN_W(IN_W), .NUM_CH(NUM_CH), .CH_W(CH_W), .STAGES(STAGES),
    .DIFF_DELAY(DIFF_DELAY), .ACC_W(ACC_W)
  ) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .inCh(inCh), .inData(inData),
    .outValid(outValid), .outCh(outCh), .outData(outData)
  );
endmodule

// File: rtl/cic_decimator_chk.sv
module cic_decimator_chk #(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2,
  parameter int ACC_W  = 20
) (
  input logic             clk,
  input logic             rst,
  input logic             inValid,
  input logic [CH_W-1:0]  inCh,
  input logic             outValid,
  input logic [CH_W-1:0]  outCh,
  input logic [ACC_W-1:0] outData
);
  // R1: reset keeps the output qualifier low on the following cycle
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> !outValid);

  // R3: an output only follows an accepted sample
  assert_out_follows_in_R3: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(inValid));

  // R3: output channel tag matches the sample that produced it
  assert_out_channel_R3: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (outCh == $past(inCh)));

  // R3: channel tag within range
  assert_out_ch_range_R3: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (int'(outCh) < NUM_CH));

  // R8: idle cycles produce no output
  assert_idle_no_out_R8: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);

  // R8: output data holds while nothing is emitted
  assert_data_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> $stable(outData));
endmodule

bind cic_decimator cic_decimator_chk #(
  .NUM_CH(NUM_CH), .CH_W(CH_W), .ACC_W(ACC_W)
) u_chk (
  .clk(clk), .rst(rst), .inValid(inValid), .inCh(inCh),
  .outValid(outValid), .outCh(outCh), .outData(outData)
);

// File: tb/tb_cic_decimator.sv
module tb_cic_decimator;
  localparam int IN_W = 8, NUM_CH = 4, STAGES = 3, DIFF_DELAY = 2;
  localparam int RATE_MIN = 2, RATE_MAX = 8;
  localparam int CH_W = 2, RATE_W = 4;
  localparam int ACC_W = IN_W + STAGES * $clog2(RATE_MAX * DIFF_DELAY);
  localparam longint MASK = (64'sd1 <<< ACC_W) - 1;
  localparam int HMAX = 64;

  logic clk = 1'b0, rst = 1'b1, inValid = 1'b0;
  logic [CH_W-1:0] inCh = '0;
  logic [IN_W-1:0] inData = '0;
  logic [RATE_W-1:0] rateIn = 4'd4;
  logic outValid;
  logic [CH_W-1:0] outCh;
  logic [ACC_W-1:0] outData;

  always #5 clk = ~clk;

  cic_decimator dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inCh(inCh), .inData(inData),
    .rateIn(rateIn), .outValid(outValid), .outCh(outCh), .outData(outData)
  );

  int nChecks = 0, nFail = 0, outCount = 0;
  bit done = 1'b0;
  longint lastOut;

  // behavioural model state
  longint cum [NUM_CH][STAGES];
  longint hist [NUM_CH][HMAX];
  int hcnt [NUM_CH];
  int mFrame, mRate;

  // stimulus table: kind, ratio, rounds
  // kind 0 impulse per channel, 1 full-scale negative step, 2 random,
  // 3 alternating full scale, 4 impulse on channel 2 only
  localparam int NROW = 6;
  localparam logic [23:0] VEC [NROW] = '{
    {8'd0, 8'd4, 8'd12}, {8'd1, 8'd8, 8'd64}, {8'd2, 8'd3, 8'd30},
    {8'd3, 8'd2, 8'd20}, {8'd2, 8'd5, 8'd25}, {8'd4, 8'd6, 8'd30}
  };

  task automatic check(bit ok, string tag, longint act, longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint binom(int n, int k);
    longint r = 1;
    for (int i = 0; i < k; i++) r = r * (n - i) / (i + 1);
    return r;
  endfunction

  function automatic int clampRate(int r);
    if (r < RATE_MIN) return RATE_MIN;
    if (r > RATE_MAX) return RATE_MAX;
    return r;
  endfunction

  task automatic modelReset();
    for (int c = 0; c < NUM_CH; c++) begin
      hcnt[c] = 0;
      for (int s = 0; s < STAGES; s++) cum[c][s] = 0;
      for (int h = 0; h < HMAX; h++) hist[c][h] = 0;
    end
    mFrame = 0;
    mRate = RATE_MIN;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    inValid = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    modelReset();
  endtask

  task automatic send(int c, int x, string tag);
    bit expOut;
    longint expVal = 0;
    longint v = longint'(x);
    if (c == 0 && mFrame == 0) mRate = clampRate(int'(rateIn));
    for (int s = 0; s < STAGES; s++) begin
      cum[c][s] = (cum[c][s] + v) & MASK;
      v = cum[c][s];
    end
    expOut = (mFrame == mRate - 1);
    if (expOut && hcnt[c] < HMAX) begin
      int m = hcnt[c];
      hist[c][m] = cum[c][STAGES-1];
      hcnt[c]++;
      for (int j = 0; j <= STAGES; j++) begin
        int idx = m - j * DIFF_DELAY;
        if (idx >= 0)
          expVal += ((j % 2) ? -binom(STAGES, j) : binom(STAGES, j)) * hist[c][idx];
      end
      expVal &= MASK;
    end
    if (c == NUM_CH - 1) mFrame = expOut ? 0 : mFrame + 1;
    @(negedge clk);
    inValid = 1'b1;
    inCh = CH_W'(c);
    inData = IN_W'(x);
    @(posedge clk);
    #1;
    inValid = 1'b0;
    check(outValid == expOut, "R3 outValid", longint'(outValid), longint'(expOut));
    if (outValid) outCount++;
    if (expOut) begin
      check(int'(outCh) == c, "R3 outCh", longint'(outCh), longint'(c));
      check(longint'(outData) == expVal, tag, longint'(outData), expVal);
      lastOut = longint'(outData);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    inValid = 1'b0;
    inCh = CH_W'($urandom_range(3));
    inData = IN_W'($urandom_range(255));
    @(posedge clk);
    #1;
    check(!outValid, "R8 idle output", longint'(outValid), 0);
  endtask

  function automatic int pattern(int kind, int f, int c);
    case (kind)
      0: return (f == 0) ? c + 1 : 0;
      1: return -128;
      2: return int'($urandom_range(255)) - 128;
      3: return (f % 2) ? 127 : -128;
      default: return (c == 2 && f == 0) ? 100 : 0;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    modelReset();
    // table-driven runs
    for (int r = 0; r < NROW; r++) begin
      int kind = int'(VEC[r][23:16]);
      string tag = (kind == 4) ? "R2 isolation" : (kind == 1) ? "R5 step" : "R4 value";
      doReset();
      rateIn = RATE_W'(VEC[r][15:8]);
      for (int f = 0; f < int'(VEC[r][7:0]); f++)
        for (int c = 0; c < NUM_CH; c++) send(c, pattern(kind, f, c), tag);
      if (kind == 1)
        check(lastOut == ((-128 * longint'(RATE_MAX * DIFF_DELAY) ** STAGES) & MASK),
              "R5 full-gain DC", lastOut, (-128 * longint'(RATE_MAX * DIFF_DELAY) ** STAGES) & MASK);
    end

    // R1: samples during reset are ignored, then state starts from zero
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      inValid = 1'b1;
      inCh = CH_W'(i % NUM_CH);
      inData = 8'h55;
      @(posedge clk);
      #1;
      check(!outValid, "R1 reset output", longint'(outValid), 0);
    end
    @(negedge clk);
    inValid = 1'b0;
    rst = 1'b0;
    modelReset();
    rateIn = 4'd2;
    for (int f = 0; f < 6; f++)
      for (int c = 0; c < NUM_CH; c++) send(c, (f == 0) ? 3 : 0, "R1 cleared state");

    // R8: idle cycles with junk between samples
    doReset();
    rateIn = 4'd3;
    for (int f = 0; f < 9; f++)
      for (int c = 0; c < NUM_CH; c++) begin
        send(c, int'($urandom_range(255)) - 128, "R8 gapped value");
        idle();
      end

    // R6: ratio changes mid-period take effect at the next period
    doReset();
    rateIn = 4'd4;
    outCount = 0;
    send(0, 10, "R6 value");
    rateIn = 4'd8;
    for (int c = 1; c < NUM_CH; c++) send(c, 10, "R6 value");
    for (int f = 1; f < 12; f++)
      for (int c = 0; c < NUM_CH; c++) send(c, 10, "R6 value");
    check(outCount == 2 * NUM_CH, "R6 output count", outCount, 2 * NUM_CH);

    // R7: ratio below minimum acts as minimum
    doReset();
    rateIn = 4'd1;
    outCount = 0;
    for (int f = 0; f < 8; f++)
      for (int c = 0; c < NUM_CH; c++) send(c, f + c, "R7 value low");
    check(outCount == 4 * NUM_CH, "R7 clamp low count", outCount, 4 * NUM_CH);

    // R7: ratio above maximum acts as maximum
    doReset();
    rateIn = 4'd15;
    outCount = 0;
    for (int f = 0; f < 16; f++)
      for (int c = 0; c < NUM_CH; c++) send(c, 5 - c, "R7 value high");
    check(outCount == 2 * NUM_CH, "R7 clamp high count", outCount, 2 * NUM_CH);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule